// File: doc/BRIEF.md
# Erasable Program Memory Control-Mode Model

This block is a synthesizable behavioural model of the control side of a 16-bit-wide, one-time or light-erasable program memory. On every cycle it takes the chip select, the output gate, a flag that the programming supply is raised, and a flag that the high identification voltage is present on address line 9. From these it picks one of seven operating modes: standby, output off, read, identification, program, verify and inhibit. It then either drives the data bus or floats it. The tri-state is split into a data vector and a separate drive-enable output, so the block can sit inside a chip and feed a real pad or a bus mux.

A small backing array holds the words. Reset or a bulk-erase input fills it with ones. A program cycle can only clear bits: the stored word becomes the old word ANDed with the presented word. Identification mode returns a manufacturer byte or a device byte, chosen by address bit 0. The array depth is a parameter and defaults to 64 words so that elaboration stays small. The mode logic does not depend on the depth.

Top module: `eprom_ctl_model`

## Requirements
- R1: After reset every stored word reads as 16'hFFFF.
- R2: With `vpp_hi` low, `ce_n` low, `oe_n` low and `a9_hv` low, `q_oe` is 1 and `q_out` equals the word stored at `addr`, in the same cycle.
- R3: With `vpp_hi` low, `ce_n` low and `oe_n` high, `q_oe` is 0. Whenever `q_oe` is 0, `q_out` is 16'h0000.
- R4: With `vpp_hi` low and `ce_n` high, `q_oe` is 0 whatever `oe_n` and `a9_hv` are.
- R5: With `vpp_hi` high, `ce_n` low and `oe_n` high, `q_oe` is 0, and at the next rising clock edge the word at `addr` becomes its old value ANDed with `d_in`.
- R6: With `vpp_hi` high, `ce_n` high and `oe_n` low, `q_oe` is 1 and `q_out` equals the word stored at `addr`.
- R7: With `vpp_hi` high, if `ce_n` and `oe_n` are both high, or both low, `q_oe` is 0 and the array is left unchanged.
- R8: With `vpp_hi` low, `ce_n` low, `oe_n` low and `a9_hv` high, `q_oe` is 1 and `q_out` is 16'h0020 when `addr[0]` is 0, or 16'h008D when `addr[0]` is 1. Bits 15..8 are zero, and the other address bits have no effect.
- R9: Programming never turns a stored 0 into a 1. Bits of `d_in` that are 1 leave the matching stored bit unchanged.
- R10: When `erase_all` is high at a rising edge, every word becomes 16'hFFFF. This takes priority over a program cycle in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; fills the array with ones |
| ce_n | input | 1 | Chip select, active low; its low level is the program pulse |
| oe_n | input | 1 | Output gate, active low |
| vpp_hi | input | 1 | Programming supply is at its raised level |
| a9_hv | input | 1 | Identification high voltage present on address line 9 |
| erase_all | input | 1 | Bulk erase, sets every word to all ones |
| addr | input | ADDR_W | Word address |
| d_in | input | 16 | Word presented for programming |
| q_out | output | 16 | Data driven toward the bus, zero when floated |
| q_oe | output | 1 | Bus drive enable |

## Verification
The bench goes after the places where the decode could choose the wrong row. One is supply raised with both controls low: a wrong design would drive or program there instead of holding the bus floated. Another is `a9_hv` asserted while `ce_n` is high or the supply is raised: a wrong design would return identification bytes in standby or verify. Identification is checked with high address bits set, which catches a design that decodes the whole address. Repeated programs of one word with ones in the data catch a design that overwrites instead of ANDing. Erase and program are applied in the same cycle, which catches a design that lets the program win.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    localparam int WORD_W = 16;
    localparam int ID_W   = 8;

    localparam logic [ID_W-1:0] MFR_ID = 8'h20;
    localparam logic [ID_W-1:0] DEV_ID = 8'h8D;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_OUT_OFF,
        M_READ,
        M_IDENT,
        M_PROG,
        M_VERIFY,
        M_INHIBIT
    } mode_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic vpp_hi;
        logic a9_hv;
    } ctl_s;

    function automatic logic [WORD_W-1:0] id_word(input logic sel);
        return {{(WORD_W-ID_W){1'b0}}, (sel ? DEV_ID : MFR_ID)};
    endfunction

    function automatic logic mode_drives(input mode_e m);
        return (m == M_READ) || (m == M_IDENT) || (m == M_VERIFY);
    endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  ctl_s  ctl,
    output mode_e mode
);
    always_comb begin
        if (ctl.vpp_hi) begin
            if (!ctl.ce_n && ctl.oe_n)       mode = M_PROG;
            else if (ctl.ce_n && !ctl.oe_n)  mode = M_VERIFY;
            else                             mode = M_INHIBIT;
        end else if (ctl.ce_n) begin
            mode = M_STANDBY;
        end else if (ctl.oe_n) begin
            mode = M_OUT_OFF;
        end else if (ctl.a9_hv) begin
            mode = M_IDENT;
        end else begin
            mode = M_READ;
        end
    end
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic hit;
        assign hit = wr_en && (addr == ADDR_W'(w));
        always_ff @(posedge clk) begin
            if (rst || erase)
                cells[w] <= '1;
            else if (hit)
                cells[w] <= cells[w] & wr_data;
        end
    end

    assign rd_data = cells[addr];
endmodule

// File: rtl/eprom_out_mux.sv
module eprom_out_mux
    import eprom_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  mode_e             mode,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              a0,
    output logic [DATA_W-1:0] q,
    output logic              q_oe
);
    always_comb begin
        q_oe = mode_drives(mode);
        unique case (mode)
            M_READ, M_VERIFY: q = rd_data;
            M_IDENT:          q = DATA_W'(id_word(a0));
            default:          q = '0;
        endcase
    end
endmodule

// File: rtl/eprom_ctl_model.sv
module eprom_ctl_model
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic              erase_all,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] d_in,
    output logic [WORD_W-1:0] q_out,
    output logic              q_oe
);
    ctl_s              ctl;
    mode_e             mode;
    logic [WORD_W-1:0] rd_word;

    assign ctl = '{ce_n: ce_n, oe_n: oe_n, vpp_hi: vpp_hi, a9_hv: a9_hv};

    eprom_mode_dec u_dec (
        .ctl  (ctl),
        .mode (mode)
    );

    eprom_cell_array #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .erase   (erase_all),
        .wr_en   (mode == M_PROG),
        .addr    (addr),
        .wr_data (d_in),
        .rd_data (rd_word)
    );

    eprom_out_mux #(.DATA_W(WORD_W)) u_mux (
        .mode    (mode),
        .rd_data (rd_word),
        .a0      (addr[0]),
        .q       (q_out),
        .q_oe    (q_oe)
    );
endmodule

// File: rtl/eprom_ctl_chk.sv
module eprom_ctl_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_n,
    input logic              vpp_hi,
    input logic              a9_hv,
    input logic              erase_all,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       d_in,
    input logic [15:0]       q_out,
    input logic              q_oe
);
    logic vfy;
    assign vfy = vpp_hi && ce_n && !oe_n;

    // R3
    float_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !q_oe |-> (q_out == 16'h0000));

    // R4
    standby_float_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_n && !vpp_hi) |-> !q_oe);

    // R3
    out_off_float_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && oe_n && !vpp_hi) |-> !q_oe);

    // R7
    inhibit_float_chk: assert property (@(posedge clk) disable iff (rst)
        (vpp_hi && (ce_n == oe_n)) |-> !q_oe);

    // R8
    ident_code_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && !vpp_hi && a9_hv) |->
            (q_oe && q_out == (addr[0] ? 16'h008D : 16'h0020)));

    // R9
    no_set_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (vfy && $past(vfy) && addr == $past(addr) && !$past(erase_all) && !$past(rst))
            |-> ((q_out & ~$past(q_out)) == 16'h0000));

    // R10
    erase_ones_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(erase_all) && !$past(rst) && vfy) |-> (q_out == 16'hFFFF));
endmodule

bind eprom_ctl_model eprom_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .a9_hv(a9_hv), .erase_all(erase_all), .addr(addr), .d_in(d_in),
    .q_out(q_out), .q_oe(q_oe)
);

// File: tb/eprom_ctl_model_bench.sv
module eprom_ctl_model_bench;
    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam time CLK_P = 20ns;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, a9_hv = 1'b0, erase_all = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       d_in = '0;
    logic [15:0]       q_out;
    logic              q_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [15:0] shadow [DEPTH];

    always #(CLK_P/2) clk = ~clk;

    eprom_ctl_model #(.ADDR_W(ADDR_W)) u_eprom_ctl_model (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .a9_hv(a9_hv), .erase_all(erase_all), .addr(addr), .d_in(d_in),
        .q_out(q_out), .q_oe(q_oe)
    );

    function automatic logic [16:0] expect_bus(input logic c, input logic o, input logic v,
                                               input logic h, input logic [ADDR_W-1:0] a,
                                               input logic [15:0] stored);
        if (v)       return (c && !o) ? {1'b1, stored} : 17'h0;
        if (c || o)  return 17'h0;
        if (h)       return {1'b1, (a[0] ? 16'h008D : 16'h0020)};
        return {1'b1, stored};
    endfunction

    task automatic step(input string tag, input logic c, input logic o, input logic v,
                        input logic h, input logic er, input logic [ADDR_W-1:0] a,
                        input logic [15:0] d);
        logic [16:0] e;
        @(negedge clk);
        ce_n = c; oe_n = o; vpp_hi = v; a9_hv = h; erase_all = er; addr = a; d_in = d;
        #2;
        e = expect_bus(c, o, v, h, a, shadow[a]);
        n_cmp++;
        if (q_oe !== e[16] || q_out !== e[15:0]) begin
            n_bad++;
            $display("FAIL %s: got oe=%b q=%h, expected oe=%b q=%h", tag, q_oe, q_out, e[16], e[15:0]);
        end
        if (er) begin
            for (int i = 0; i < DEPTH; i++) shadow[i] = 16'hFFFF;
        end else if (v && !c && o) begin
            shadow[a] = shadow[a] & d;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0B1D));
        for (int i = 0; i < DEPTH; i++) shadow[i] = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset contents
        step("R1", 0, 0, 0, 0, 0, 6'd0,  16'h0);
        step("R1", 0, 0, 0, 0, 0, 6'd63, 16'h0);
        // R5 program, R6 verify
        step("R5", 0, 1, 1, 0, 0, 6'd5, 16'h1234);
        step("R6", 1, 0, 1, 0, 0, 6'd5, 16'h0);
        // R9 ones in data do not set bits
        step("R9", 0, 1, 1, 0, 0, 6'd5, 16'hFFFF);
        step("R9", 1, 0, 1, 0, 0, 6'd5, 16'h0);
        step("R9", 0, 1, 1, 0, 0, 6'd5, 16'hF0F0);
        step("R9", 1, 0, 1, 0, 0, 6'd5, 16'h0);
        // R2 read
        step("R2", 0, 0, 0, 0, 0, 6'd5, 16'h0);
        step("R2", 0, 0, 0, 0, 0, 6'd4, 16'h0);
        // R3 output off
        step("R3", 0, 1, 0, 1, 0, 6'd5, 16'h0);
        // R4 standby
        step("R4", 1, 0, 0, 1, 0, 6'd5, 16'h0);
        step("R4", 1, 1, 0, 0, 0, 6'd5, 16'h0);
        // R7 inhibit rows leave array alone
        step("R7", 1, 1, 1, 0, 0, 6'd5, 16'h0000);
        step("R7", 0, 0, 1, 1, 0, 6'd5, 16'h0000);
        step("R7", 1, 0, 1, 0, 0, 6'd5, 16'h0);
        // R8 identification, high address bits set
        step("R8", 0, 0, 0, 1, 0, 6'b111110, 16'h0);
        step("R8", 0, 0, 0, 1, 0, 6'b101011, 16'h0);
        step("R8", 1, 0, 1, 1, 0, 6'd5, 16'h0);
        // R10 erase wins over program
        step("R10", 0, 1, 1, 0, 1, 6'd9, 16'h0000);
        step("R10", 1, 0, 1, 0, 0, 6'd9, 16'h0);
        step("R10", 1, 0, 1, 0, 0, 6'd5, 16'h0);

        for (int k = 0; k < 600; k++) begin
            logic [31:0] r;
            r = $urandom;
            step("R2", r[0], r[1], r[2], r[3] & r[4], ($urandom % 50) == 0,
                 ADDR_W'($urandom % 8), 16'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule